// File: doc/BRIEF.md
# Multi-link TDM serial receiver

This block receives time-division-multiplexed serial traffic on up to eight data links. All links share one bit clock and one frame sync. It locks its bit counter to the rising edge of the frame sync. From that point it counts bits and 8-bit timeslots, and it shifts each link's bits into a byte, most significant bit first. When a slot completes, every active link presents its byte together with a per-link strobe and the shared slot number. The position of a link in the output vector gives its link index.

A rate selector sets the per-link bit rate to the base rate, twice the base rate or four times the base rate. The frame grows to 1024, 2048 or 4096 bits, and the number of usable links falls to 8, 4 or 2. A separate mode input declares that the clock runs at twice the bit rate, in which case one clock in two is sampled. After alignment, a frame sync edge at the wrong bit position raises a one-cycle error and restarts the frame at the new edge.

Top module: `tdm_rx`

## Requirements
- R1: A rising edge of `fsync_i` marks bit 0 of a frame. The data sampled on the clock where the edge is seen is the MSB of slot 0.
- R2: Bits are shifted in MSB first. The byte and its strobe appear on the outputs in the cycle after the clock that samples the eighth bit of a slot. `byte_o[8*l+7:8*l]` belongs to link l.
- R3: `slot_o` gives the number of the completed slot. A frame holds 1024 << s bits, where s is 0, 1 or 2 for `rate_i` = 0, 1 and 2 (3 behaves like 2). After the last slot, counting wraps to slot 0 without a new sync.
- R4: Only the rising edge of `fsync_i` realigns the receiver. A sync held high for many clocks does not restart counting.
- R5: With `clk2x_i`=1, the clock that sees the sync edge is sampled, then every second clock after it. Each bit is held for two clocks.
- R6: If, once aligned, a sync edge falls on any clock other than the sampling clock of bit 0, `frame_err_o` is high for exactly one cycle and the frame restarts at that edge. The first edge after reset raises no error.
- R7: Link l is active when l < 8 >> s. All active links strobe together in the same cycle.
- R8: Inactive links keep their `byte_o` field at zero and never assert their `valid_o` bit.
- R9: In reset and until the first sync edge, every output is zero and no strobe is issued.
- R10: A strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | 2 | Per-link rate: 0 base, 1 double, 2 or 3 quadruple |
| clk2x_i | input | 1 | 1: clock runs at twice the bit rate |
| fsync_i | input | 1 | Frame sync, one or more clocks wide |
| data_i | input | LINKS | Serial data, one bit per link |
| byte_o | output | 8*LINKS | Assembled bytes, link l in bits 8l+7..8l |
| valid_o | output | LINKS | Per-link byte strobe |
| slot_o | output | SLOT_W | Slot number of the completed byte |
| frame_err_o | output | 1 | Misplaced frame sync, one-cycle pulse |

## Verification
A realignment and a byte strobe can compete around the same clock. A sync edge that arrives mid-byte must throw away the partial byte and raise the error. A sync edge that arrives right after a slot's last bit must still let that slot's strobe out. The bench provokes this by cutting frames short at bit counts that do and do not divide by eight, in both clock modes, and then starting a new frame at once. Its model predicts the error pulse, the missing strobe and the slot 0 restart cycle by cycle, and it compares them with the outputs on every clock.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned MAX_SHIFT = 2;

  function automatic logic [1:0] rate_shift(input logic [1:0] rate);
    case (rate)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/tdm_rx_timing.sv
module tdm_rx_timing
  import tdm_rx_pkg::*;
#(
  parameter int unsigned BASE_BITS = 1024,
  parameter int unsigned CNT_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       rate_i,
  input  logic             clk2x_i,
  input  logic             fsync_i,
  output logic             samp_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] LAST0 = CNT_W'(BASE_BITS - 1);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(2 * BASE_BITS - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(4 * BASE_BITS - 1);

  logic             fs_q, aligned_q, ph_q;
  logic [CNT_W-1:0] cnt_q, last_bit;
  logic             rise, nominal;

  always_comb begin
    case (rate_shift(rate_i))
      2'd0:    last_bit = LAST0;
      2'd1:    last_bit = LAST1;
      default: last_bit = LAST2;
    endcase
  end

  assign rise    = fsync_i & ~fs_q;
  // ph_q marks the sampling clock in 2x mode
  assign nominal = aligned_q & (~clk2x_i | ph_q);
  assign samp_o  = rise | nominal;
  assign idx_o   = rise ? '0 : cnt_q;
  assign err_o   = rise & aligned_q & ~(nominal & (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q      <= 1'b0;
      aligned_q <= 1'b0;
      ph_q      <= 1'b1;
      cnt_q     <= '0;
    end else begin
      fs_q <= fsync_i;
      if (rise) aligned_q <= 1'b1;
      if (rise)         ph_q <= ~clk2x_i;
      else if (clk2x_i) ph_q <= ~ph_q;
      else              ph_q <= 1'b1;
      if (samp_o) cnt_q <= (idx_o == last_bit) ? '0 : idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       samp_i,
  input  logic       last_i,
  input  logic       bit_i,
  output logic [7:0] byte_o,
  output logic       valid_o
);
  logic [6:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else if (!active_i) begin
      sr_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= samp_i & last_i;
      if (samp_i) begin
        sr_q <= {sr_q[5:0], bit_i};
        if (last_i) byte_o <= {sr_q, bit_i};
      end
    end
  end
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_rx_pkg::*;
#(
  parameter  int unsigned LINKS     = 8,
  parameter  int unsigned BASE_BITS = 1024,
  localparam int unsigned CNT_W     = $clog2(BASE_BITS) + MAX_SHIFT,
  localparam int unsigned SLOT_W    = CNT_W - 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          rate_i,
  input  logic                clk2x_i,
  input  logic                fsync_i,
  input  logic [LINKS-1:0]    data_i,
  output logic [LINKS*8-1:0]  byte_o,
  output logic [LINKS-1:0]    valid_o,
  output logic [SLOT_W-1:0]   slot_o,
  output logic                frame_err_o
);
  logic             samp, err, last;
  logic [CNT_W-1:0] idx;
  logic [1:0]       shift;
  logic [LINKS-1:0] act;

  tdm_rx_timing #(.BASE_BITS(BASE_BITS), .CNT_W(CNT_W)) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (rate_i),
    .clk2x_i (clk2x_i),
    .fsync_i (fsync_i),
    .samp_o  (samp),
    .idx_o   (idx),
    .err_o   (err)
  );

  assign shift = rate_shift(rate_i);
  assign last  = (idx[2:0] == 3'd7);

  for (genvar l = 0; l < LINKS; l++) begin : g_lane
    assign act[l] = (32'(l) < (LINKS >> shift));
    tdm_rx_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (act[l]),
      .samp_i   (samp),
      .last_i   (last),
      .bit_i    (data_i[l]),
      .byte_o   (byte_o[8*l +: 8]),
      .valid_o  (valid_o[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o      <= '0;
      frame_err_o <= 1'b0;
    end else begin
      frame_err_o <= err;
      if (samp && last) slot_o <= idx[CNT_W-1:3];
    end
  end
endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk
  import tdm_rx_pkg::*;
#(
  parameter int unsigned LINKS  = 8,
  parameter int unsigned SLOT_W = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         rate_i,
  input logic               fsync_i,
  input logic [LINKS*8-1:0] byte_o,
  input logic [LINKS-1:0]   valid_o,
  input logic               frame_err_o
);
  logic [1:0]       rate_q;
  logic             seen_q;
  logic [LINKS-1:0] act_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      seen_q <= 1'b0;
    end else begin
      rate_q <= rate_i;
      if (fsync_i) seen_q <= 1'b1;
    end
  end

  always_comb
    for (int l = 0; l < LINKS; l++)
      act_c[l] = (l < int'(LINKS >> rate_shift(rate_q)));

  a_r10_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid_o) |=> !(|valid_o));

  a_r6_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);

  a_r8_no_inactive_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o & ~act_c) == '0);

  a_r7_strobe_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid_o) |-> (valid_o == act_c));

  a_r9_quiet_before_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (valid_o == '0 && !frame_err_o));

  for (genvar l = 0; l < LINKS; l++) begin : g_zero
    a_r8_inactive_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_c[l] |-> (byte_o[8*l +: 8] == 8'h00));
  end
endmodule

bind tdm_rx tdm_rx_chk #(.LINKS(LINKS), .SLOT_W(SLOT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rate_i      (rate_i),
  .fsync_i     (fsync_i),
  .byte_o      (byte_o),
  .valid_o     (valid_o),
  .frame_err_o (frame_err_o)
);

// File: tb/tb_tdm_rx.sv
module tb_tdm_rx;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 8;
  localparam int SW = 9;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    rate = 2'd0;
  logic          x2 = 1'b0;
  logic          fsync = 1'b0;
  logic [L-1:0]  data = '0;
  logic [L*8-1:0] byte_o;
  logic [L-1:0]  valid_o;
  logic [SW-1:0] slot_o;
  logic          err_o;

  logic [L*8-1:0] exp_byte, nxt_byte;
  logic [L-1:0]   exp_valid, nxt_valid;
  logic [SW-1:0]  exp_slot, nxt_slot;
  logic           exp_err, nxt_err;
  int  n_chk = 0, n_bad = 0;
  bit  aligned_m = 0, done = 0;
  int  cnt_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .rate_i(rate), .clk2x_i(x2), .fsync_i(fsync),
    .data_i(data), .byte_o(byte_o), .valid_o(valid_o), .slot_o(slot_o), .frame_err_o(err_o)
  );

  function automatic int shf(input logic [1:0] r);
    return (r == 2'd0) ? 0 : (r == 2'd1) ? 1 : 2;
  endfunction

  function automatic logic [L-1:0] act_mask(input logic [1:0] r);
    logic [L-1:0] m;
    for (int l = 0; l < L; l++) m[l] = (l < (L >> shf(r)));
    return m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic compare();
    logic [L-1:0] m;
    m = act_mask(rate);
    chk("R7 strobes", 64'(valid_o), 64'(exp_valid));
    chk("R2 bytes", byte_o & {L*8{1'b1}}, exp_byte);
    chk("R3 slot", 64'(slot_o), 64'(exp_slot));
    chk("R6 frame error", 64'(err_o), 64'(exp_err));
    for (int l = 0; l < L; l++)
      if (!m[l]) chk("R8 inactive link", {55'd0, valid_o[l], byte_o[8*l +: 8]}, 64'd0);
  endtask

  task automatic step(input logic fs, input logic [L-1:0] d);
    @(negedge clk);
    compare();
    fsync = fs;
    data  = d;
    exp_byte = nxt_byte; exp_valid = nxt_valid; exp_slot = nxt_slot; exp_err = nxt_err;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      nxt_valid = '0; nxt_err = 1'b0;
      step(1'b0, L'($urandom));
    end
  endtask

  task automatic do_reset(input logic [1:0] r, input logic m2);
    @(negedge clk);
    rst_ni = 1'b0; fsync = 1'b0; rate = r; x2 = m2;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset outputs", {err_o, slot_o, valid_o, byte_o[45:0]}, 64'd0);
    chk("R9 reset bytes", byte_o, 64'd0);
    rst_ni = 1'b1;
    exp_byte = '0; exp_valid = '0; exp_slot = '0; exp_err = 1'b0;
    nxt_byte = '0; nxt_valid = '0; nxt_slot = '0; nxt_err = 1'b0;
    aligned_m = 0; cnt_m = 0;
    idle(6); // R9: no strobe before first sync
  endtask

  // Drives nbits bits of a frame starting with a sync edge of fsw clocks (R1 R4 R5)
  task automatic send_frame(input int nbits, input int fsw);
    int flen, cpb, k;
    logic [7:0] cur [L];
    logic [L-1:0] m, bv;
    bit err_here;
    flen = 1024 << shf(rate);
    cpb  = x2 ? 2 : 1;
    m    = act_mask(rate);
    err_here = aligned_m && (cnt_m != 0);
    k = 0;
    for (int b = 0; b < nbits; b++) begin
      if (b % 8 == 0) for (int l = 0; l < L; l++) cur[l] = 8'($urandom);
      for (int l = 0; l < L; l++) bv[l] = cur[l][7 - (b % 8)];
      for (int c = 0; c < cpb; c++) begin
        nxt_valid = '0;
        nxt_err   = (b == 0 && c == 0) ? err_here : 1'b0;
        if (c == 0 && (b % 8) == 7) begin
          nxt_valid = m;
          nxt_slot  = SW'(b / 8);
          for (int l = 0; l < L; l++) nxt_byte[8*l +: 8] = m[l] ? cur[l] : 8'h00;
        end
        step(k < fsw, bv);
        k++;
      end
    end
    aligned_m = 1;
    cnt_m = (nbits == flen) ? 0 : nbits;
  endtask

  function automatic int flen_now();
    return 1024 << shf(rate);
  endfunction

  function automatic int rnd_w();
    return 1 + int'($urandom % 16);
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    // base rate, 1x clock
    do_reset(2'd0, 1'b0);
    send_frame(flen_now(), 1);
    send_frame(flen_now(), rnd_w());      // R4 wide sync, no error
    send_frame(flen_now(), rnd_w());      // R3 continuous wrap
    send_frame(300, rnd_w());             // R6 cut mid-byte
    send_frame(flen_now(), rnd_w());      // R6 error expected here
    send_frame(256, 2);                   // R6 cut on slot boundary
    send_frame(flen_now(), rnd_w());
    // base rate, 2x clock (R5)
    do_reset(2'd0, 1'b1);
    send_frame(flen_now(), rnd_w());
    send_frame(77, rnd_w());
    send_frame(flen_now(), rnd_w());
    // double rate, four links (R7)
    do_reset(2'd1, 1'b0);
    send_frame(flen_now(), rnd_w());
    send_frame(flen_now(), rnd_w());
    do_reset(2'd1, 1'b1);
    send_frame(flen_now(), rnd_w());
    send_frame(45, 3);
    send_frame(flen_now(), rnd_w());
    // quadruple rate, two links, very wide sync (R4 R8)
    do_reset(2'd2, 1'b0);
    send_frame(flen_now(), 40);
    send_frame(flen_now(), rnd_w());
    // rate code 3 behaves as quadruple (R3 R7)
    do_reset(2'd3, 1'b0);
    send_frame(flen_now(), rnd_w());
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule